// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Per-Line Polarity

This block is a secondary interrupt controller. It collects a set of request lines, by default 18, and merges them into one level request toward a parent controller. Each request line first passes through a synchroniser. A per-line polarity bit then turns it into an internal active-high request. A sticky status bit records the request. Software clears that bit by writing ones to a clear register. The cascade request is raised when at least one line has both its status bit and its enable bit set, and only while the controller is globally switched on.

Software reaches the block over a plain synchronous register bus with an address, a write strobe, write data and combinational read data. The control word holds two settings: the global switch and the choice between level capture and edge capture. Masking a line and clearing its pending status are separate operations. A masked line therefore keeps its status bit, and it raises the cascade again as soon as it is unmasked.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While reset is held, every register reads 0: control, enable, status and polarity.
- R2: Register offsets are fixed as follows: control 0x00, enable 0x04, status 0x08, clear 0x0C and polarity 0x10. Control keeps only bit 31 and bit 30. Enable and polarity keep bits 17:0. Reads of the clear offset, of any unmapped offset and of any unimplemented bit return 0.
- R3: While control bit 31 (the global switch) is 0, the cascade output is 0 whatever the pending state is.
- R4: The cascade output is 1 exactly when control bit 31 is 1 and the bitwise AND of enable and status is nonzero. It follows the register state in the same cycle.
- R5: A polarity bit of 1 makes its line active-high. A polarity bit of 0 makes its line active-low.
- R6: A request change that is applied before rising edge k reaches the status register at edge k+2. This delay comes from two synchroniser stages plus the capture flop.
- R7: In level mode (control bit 30 = 0), a status bit is set on every cycle its request is active. It therefore sets again right after a clear if the line is still active.
- R8: In edge mode (control bit 30 = 1), a status bit is set only when the request goes from inactive to active. A request that stays active does not set the bit again after a clear.
- R9: A write to the clear offset clears each status bit whose write-data bit is 1. Status bits written with 0 keep their value. Status bits otherwise stay set until they are cleared.
- R10: When a clear and a capture hit the same status bit in the same cycle, the bit stays set.
- R11: Clearing an enable bit leaves its status bit unchanged. Setting the enable bit again with the status still pending raises the cascade.
- R12: Writes to the status offset have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| req_in | input | N_LINES (18) | Raw asynchronous request lines |
| cascade_irq | output | 1 | Active-high merged request to the parent controller |

## Verification
A register write takes effect at the rising edge that samples the strobe. The cascade output and read data follow the register state with no further delay, so the bench checks them one time step after the next falling edge. A change on a request line reaches the status register at the third rising edge after it is applied. The bench therefore reads status two edges and three edges after such a change and expects it to be absent, then present. A behavioural reference model advances at every rising edge, and the cascade output is compared with it at every falling edge, away from the edge that moves the design.

// File: rtl/cic_pkg.sv
package cic_pkg;

   localparam int unsigned CIC_OFF_CTRL  = 'h00;
   localparam int unsigned CIC_OFF_EN    = 'h04;
   localparam int unsigned CIC_OFF_STAT  = 'h08;
   localparam int unsigned CIC_OFF_CLR   = 'h0C;
   localparam int unsigned CIC_OFF_POL   = 'h10;

   typedef enum logic {
      CAP_LEVEL = 1'b0,
      CAP_EDGE  = 1'b1
   } cap_mode_e;

endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
   parameter int unsigned WIDTH  = 18,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_in};
         end
      end
   endgenerate

   assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/cic_capture.sv
module cic_capture
   import cic_pkg::*;
#(
   parameter int unsigned N_LINES = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] sync_i,
   input  logic [N_LINES-1:0] pol_i,
   input  cap_mode_e          mode_i,
   input  logic [N_LINES-1:0] clr_i,
   output logic [N_LINES-1:0] status_o,
   output logic [N_LINES-1:0] cap_o
);

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         logic active;
         logic prev_q;
         logic hit;
         logic flag_q;

         // polarity 1 keeps the line as is, 0 inverts it
         assign active = ~(sync_i[i] ^ pol_i[i]);
         assign hit    = (mode_i == CAP_EDGE) ? (active & ~prev_q) : active;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               flag_q <= 1'b0;
            end else begin
               prev_q <= active;
               flag_q <= hit | (flag_q & ~clr_i[i]);
            end
         end

         assign status_o[i] = flag_q;
         assign cap_o[i]    = hit;
      end
   endgenerate

endmodule

// File: rtl/cic_regs.sv
module cic_regs
   import cic_pkg::*;
#(
   parameter int unsigned N_LINES = 18,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [N_LINES-1:0] status_i,
   output logic               glob_en_o,
   output cap_mode_e          mode_o,
   output logic [N_LINES-1:0] en_o,
   output logic [N_LINES-1:0] pol_o,
   output logic [N_LINES-1:0] clr_o
);

   localparam int unsigned BIT_GEN  = DATA_W - 1;
   localparam int unsigned BIT_MODE = DATA_W - 2;

   logic       hit_ctrl, hit_en, hit_stat, hit_clr, hit_pol;
   logic       glob_en_q;
   cap_mode_e  mode_q;
   logic [N_LINES-1:0] en_q, pol_q;
   logic       wdata_unused;

   assign hit_ctrl = (bus_addr == ADDR_W'(CIC_OFF_CTRL));
   assign hit_en   = (bus_addr == ADDR_W'(CIC_OFF_EN));
   assign hit_stat = (bus_addr == ADDR_W'(CIC_OFF_STAT));
   assign hit_clr  = (bus_addr == ADDR_W'(CIC_OFF_CLR));
   assign hit_pol  = (bus_addr == ADDR_W'(CIC_OFF_POL));

   assign wdata_unused = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en_q <= 1'b0;
         mode_q    <= CAP_LEVEL;
         en_q      <= '0;
         pol_q     <= '0;
      end else if (bus_we) begin
         if (hit_ctrl) begin
            glob_en_q <= bus_wdata[BIT_GEN];
            mode_q    <= bus_wdata[BIT_MODE] ? CAP_EDGE : CAP_LEVEL;
         end
         if (hit_en)  en_q  <= bus_wdata[N_LINES-1:0];
         if (hit_pol) pol_q <= bus_wdata[N_LINES-1:0];
      end
   end

   assign clr_o = (bus_we && hit_clr) ? bus_wdata[N_LINES-1:0] : '0;

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[BIT_GEN]  = glob_en_q;
         bus_rdata[BIT_MODE] = (mode_q == CAP_EDGE);
      end else if (hit_en) begin
         bus_rdata[N_LINES-1:0] = en_q;
      end else if (hit_stat) begin
         bus_rdata[N_LINES-1:0] = status_i;
      end else if (hit_pol) begin
         bus_rdata[N_LINES-1:0] = pol_q;
      end
   end

   assign glob_en_o = glob_en_q;
   assign mode_o    = mode_q;
   assign en_o      = en_q;
   assign pol_o     = pol_q;

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
   import cic_pkg::*;
#(
   parameter int unsigned N_LINES     = 18,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [N_LINES-1:0] req_in,
   output logic               cascade_irq
);

   generate
      if (N_LINES < 1 || N_LINES + 2 > DATA_W) begin : g_bad_lines
         $error("cascade_irq_ctrl: N_LINES must leave the two control bits free");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("cascade_irq_ctrl: ADDR_W too small for the register map");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("cascade_irq_ctrl: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [N_LINES-1:0] req_sync;
   logic [N_LINES-1:0] status_q;
   logic [N_LINES-1:0] cap_vec;
   logic [N_LINES-1:0] clr_vec;
   logic [N_LINES-1:0] en_vec;
   logic [N_LINES-1:0] pol_vec;
   logic               glob_en;
   cap_mode_e          mode;

   cic_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (req_in),
      .d_out (req_sync)
   );

   cic_capture #(
      .N_LINES (N_LINES)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (req_sync),
      .pol_i    (pol_vec),
      .mode_i   (mode),
      .clr_i    (clr_vec),
      .status_o (status_q),
      .cap_o    (cap_vec)
   );

   cic_regs #(
      .N_LINES (N_LINES),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .status_i  (status_q),
      .glob_en_o (glob_en),
      .mode_o    (mode),
      .en_o      (en_vec),
      .pol_o     (pol_vec),
      .clr_o     (clr_vec)
   );

   assign cascade_irq = glob_en & (|(en_vec & status_q));

endmodule

// File: rtl/cic_checker.sv
module cic_checker
   import cic_pkg::*;
#(
   parameter int unsigned N_LINES = 18,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_we,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               cascade_irq,
   input logic [N_LINES-1:0] status_q,
   input logic [N_LINES-1:0] cap_vec,
   input logic [N_LINES-1:0] clr_vec
);

   logic addr_unmapped;
   assign addr_unmapped = (bus_addr != ADDR_W'(CIC_OFF_CTRL)) &&
                          (bus_addr != ADDR_W'(CIC_OFF_EN))   &&
                          (bus_addr != ADDR_W'(CIC_OFF_STAT)) &&
                          (bus_addr != ADDR_W'(CIC_OFF_POL));

   // R3: switching the controller off silences the cascade from the next cycle
   p_off_quiets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(CIC_OFF_CTRL) && !bus_wdata[DATA_W-1])
      |=> !cascade_irq);

   // R4: the cascade never rises without a pending status bit
   p_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cascade_irq |-> (status_q != '0));

   // R2: clear and unmapped offsets read as zero
   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_unmapped |-> (bus_rdata == '0));

   // R9: a cleared bit with no capture in that cycle is zero afterwards
   p_clear_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(clr_vec & ~cap_vec)) == '0));

   // R10: a capture in the same cycle as a clear leaves the bit set
   p_capture_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_vec != '0) |=> ((status_q & $past(cap_vec)) == $past(cap_vec)));

   // R11: without a clear, no status bit ever falls (masking included)
   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

bind cascade_irq_ctrl cic_checker #(
   .N_LINES (N_LINES),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) u_cic_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_we      (bus_we),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .cascade_irq (cascade_irq),
   .status_q    (status_q),
   .cap_vec     (cap_vec),
   .clr_vec     (clr_vec)
);

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb;

   localparam int N = 18;
   localparam logic [N-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  raw = '0;
   logic          irq;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cascade_irq_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (addr),
      .bus_we      (we),
      .bus_wdata   (wdata),
      .bus_rdata   (rdata),
      .req_in      (raw),
      .cascade_irq (irq)
   );

   // behavioural reference model
   bit          m_on, m_edge;
   bit [N-1:0]  m_en, m_pol, m_stat, m_last;
   bit [N-1:0]  m_delay[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_on = 0; m_edge = 0; m_en = '0; m_pol = '0; m_stat = '0; m_last = '0;
         m_delay = {};
         m_delay.push_back('0);
         m_delay.push_back('0);
      end else begin : upd
         bit [N-1:0] seen, act, hit, wipe;
         seen = m_delay[0];
         act  = ~(seen ^ m_pol);
         hit  = m_edge ? (act & ~m_last) : act;
         wipe = (we && addr == 8'h0C) ? wdata[N-1:0] : '0;
         m_stat = hit | (m_stat & ~wipe);
         m_last = act;
         void'(m_delay.pop_front());
         m_delay.push_back(raw);
         if (we) begin
            if (addr == 8'h00) begin m_on = wdata[31]; m_edge = wdata[30]; end
            if (addr == 8'h04) m_en  = wdata[N-1:0];
            if (addr == 8'h10) m_pol = wdata[N-1:0];
         end
      end
   end

   // per-cycle comparison of the cascade output (R4)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         vectors++;
         if (irq !== (m_on & (|(m_en & m_stat)))) begin
            miscompares++;
            $display("FAIL R4 cascade got %0b exp %0b at %0t", irq,
                     m_on & (|(m_en & m_stat)), $time);
         end
      end
   end

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got %08h exp %08h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      #1;
      check(rdata, exp, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1: reset state
      rd(8'h00, 32'h0, "R1 ctrl");
      rd(8'h04, 32'h0, "R1 enable");
      rd(8'h08, 32'h0, "R1 status");
      rd(8'h10, 32'h0, "R1 polarity");
      @(negedge clk);
      rst_n = 1'b1;

      // all lines active-high, then clear what floods in at reset
      wr(8'h10, 32'(ALL));
      step(3);
      wr(8'h0C, 32'(ALL));
      rd(8'h08, 32'h0, "R9 clear all");
      wr(8'h04, 32'(ALL));
      wr(8'h00, 32'h8000_0000);
      check(32'(irq), 32'h0, "R4 idle cascade");

      // R6: latency of three edges
      raw[3] = 1'b1;
      step(2);
      rd(8'h08, 32'h0, "R6 not yet captured");
      step(1);
      rd(8'h08, 32'h8, "R6 captured on third edge");
      check(32'(irq), 32'h1, "R4 cascade raised");

      // R7/R10: level line still active beats the clear
      wr(8'h0C, 32'h8);
      rd(8'h08, 32'h8, "R10 capture wins over clear");
      step(2);
      rd(8'h08, 32'h8, "R7 level re-asserts");
      raw[3] = 1'b0;
      step(4);
      rd(8'h08, 32'h8, "R9 sticky after release");
      wr(8'h0C, 32'h10);
      rd(8'h08, 32'h8, "R9 zero bits untouched");
      wr(8'h0C, 32'h8);
      rd(8'h08, 32'h0, "R9 one bit clears");

      // R5: active-low line
      wr(8'h10, 32'(ALL & ~(N'(1) << 5)));
      step(3);
      rd(8'h08, 32'h20, "R5 low level is active");
      raw[5] = 1'b1;
      step(4);
      wr(8'h0C, 32'h20);
      step(2);
      rd(8'h08, 32'h0, "R5 high level inactive when active-low");
      raw[5] = 1'b0;
      step(3);
      wr(8'h10, 32'(ALL));
      step(2);
      wr(8'h0C, 32'(ALL));
      rd(8'h08, 32'h0, "R5 restore");

      // R8: edge mode
      wr(8'h00, 32'hC000_0000);
      raw[7] = 1'b1;
      step(3);
      rd(8'h08, 32'h80, "R8 rising edge captured");
      wr(8'h0C, 32'h80);
      step(3);
      rd(8'h08, 32'h0, "R8 held level not recaptured");
      raw[7] = 1'b0;
      step(3);
      rd(8'h08, 32'h0, "R8 falling edge ignored");
      raw[7] = 1'b1;
      step(3);
      rd(8'h08, 32'h80, "R8 second edge captured");

      // R11: masking keeps status
      wr(8'h04, 32'h0);
      check(32'(irq), 32'h0, "R11 masked cascade low");
      rd(8'h08, 32'h80, "R11 status kept while masked");
      wr(8'h04, 32'h80);
      check(32'(irq), 32'h1, "R11 unmask raises cascade");

      // R3: global switch
      wr(8'h00, 32'h4000_0000);
      check(32'(irq), 32'h0, "R3 switched off");
      step(3);
      check(32'(irq), 32'h0, "R3 stays off");
      wr(8'h00, 32'hC000_0000);
      check(32'(irq), 32'h1, "R3 switched on");

      // R12: status not writable
      wr(8'h08, 32'h0);
      rd(8'h08, 32'h80, "R12 write zero ignored");
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, 32'h80, "R12 write ones ignored");

      // R2: map and unused bits
      rd(8'h0C, 32'h0, "R2 clear reads zero");
      rd(8'h14, 32'h0, "R2 unmapped reads zero");
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'(ALL), "R2 enable width");
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'hC000_0000, "R2 control bits");
      rd(8'h10, 32'(ALL), "R2 polarity width");

      // mixed traffic against the model
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         raw = N'($urandom);
         if (i % 7 == 3) begin
            addr = 8'h0C; wdata = $urandom; we = 1'b1;
         end else if (i % 53 == 10) begin
            addr = 8'h00; wdata = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 30'h0}; we = 1'b1;
         end else if (i % 41 == 5) begin
            addr = 8'h04; wdata = $urandom; we = 1'b1;
         end else begin
            we = 1'b0;
            addr = 8'h08;
            #1;
            check(rdata, 32'(m_stat), "R7 R8 status vs model");
         end
      end
      @(negedge clk);
      we = 1'b0;
      step(2);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule